// File: doc/BRIEF.md
# Programmable Interface Protocol Checker

This block watches a bundle of control signals on one on-chip interface and decides, every clock cycle, whether the observed activity belongs to a known protocol. Each distinct value of the sampled bundle is an event. A programmable table of legal event values is searched in parallel, like a content-addressable memory. A hit is reduced to an event index by a priority encoder. The index from the previous checked cycle is held in a register, and the pair (previous index, current index) is then looked up in a second programmable table of legal transitions.

Both tables are loaded through write ports that carry an address, the data and a valid bit, normally before checking is turned on. A transition entry names its two endpoints by the indexes that the events received in the event table. When the event lookup or the transition lookup misses, the checker latches a sticky error with its cause, raises a halt request so the surrounding system can stop, and freezes its outputs. It stays that way until software clears the error.

Control is a four-state machine. IDLE means checking is off. PRIME checks the first sample after enable against the event table only. CHECK checks both the event and the transition. HALTED holds a detected error. The named transitions are:
- IDLE to PRIME (enable high).
- PRIME to CHECK (event hit).
- PRIME to HALTED (event miss).
- CHECK to CHECK (both hit).
- CHECK to HALTED (either miss).
- PRIME or CHECK to IDLE (enable low).
- HALTED to IDLE (clear).

Top module: `proto_checker`

## Requirements
- R1: After reset `evt_valid`, `err_flag` and `halt_req` are 0 and `err_cause` is 2'b00 (none).
- R2: A vector sampled in PRIME or CHECK that equals a valid event entry gives `evt_valid`=1 and `evt_idx` = that entry's address. These outputs are visible from the clock edge that samples the vector.
- R3: When several valid event entries hold the same value, the lowest address is reported.
- R4: An event entry written with its valid bit clear never matches, including an entry that was valid before and is rewritten as invalid.
- R5: A sampled vector that matches no valid event entry sets `err_flag`=1, `halt_req`=1 and `err_cause`=2'b01, with `evt_valid`=0, from the sampling edge.
- R6: In CHECK, a pair (previous index, current index) that no valid transition entry holds sets `err_flag`=1, `halt_req`=1 and `err_cause`=2'b10. In that case `evt_valid`=1 and `evt_idx` is the current index. A repeated event needs its own self-transition entry.
- R7: The first sample after checking is enabled is checked only against the event table, whatever index was held before.
- R8: Once HALTED, the error, the cause, the halt request and the event outputs stay unchanged and samples are ignored until `err_clr`. `err_clr` returns the block to IDLE with all four of those outputs cleared.
- R9: While `chk_en` is low, samples are ignored: no error is raised and `evt_valid` is 0. Raising `chk_en` again enters PRIME one edge later.
- R10: A transition entry is legal only while its valid bit is set. Rewriting it with the valid bit clear makes its pair illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_we | input | 1 | Event table write strobe |
| evt_waddr | input | EIW | Event entry address |
| evt_wdata | input | SIG_W | Event value to store |
| evt_wvalid | input | 1 | Valid bit of the written event entry |
| trn_we | input | 1 | Transition table write strobe |
| trn_waddr | input | TAW | Transition entry address |
| trn_wsrc | input | EIW | Source event index of the written transition |
| trn_wdst | input | EIW | Destination event index of the written transition |
| trn_wvalid | input | 1 | Valid bit of the written transition entry |
| chk_en | input | 1 | Checking enable |
| err_clr | input | 1 | Clears a held error |
| sample_vec | input | SIG_W | Monitored interface signals |
| evt_valid | output | 1 | A known event was matched on the last sample |
| evt_idx | output | EIW | Index of the matched event |
| err_flag | output | 1 | Sticky error |
| err_cause | output | 2 | 00 none, 01 unknown event, 10 illegal transition |
| halt_req | output | 1 | Request to suspend execution |

## Verification
The bench targets several corner cases, each chosen because a specific wrong design would fail it:
- A value loaded into two event slots must report the lower slot. An encoder that picks the highest bit would report the other slot.
- Event and transition entries that are rewritten as invalid must stop matching. A design that ignores the valid bit would pass those vectors as legal.
- The first sample after enable or after a clear follows a pair that was never programmed. A design that checks the stale previous index would halt there falsely.
- Vectors that would be illegal are driven while the checker is disabled and while it is halted. A design that kept sampling in those states would raise errors or overwrite the frozen index and cause.

// File: rtl/pc_pkg.sv
package pc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PRIME  = 2'd1,
        ST_CHECK  = 2'd2,
        ST_HALTED = 2'd3
    } pc_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'b00,
        CAUSE_UNKNOWN = 2'b01,
        CAUSE_ILLEGAL = 2'b10
    } pc_cause_e;

endpackage

// File: rtl/pc_event_cam.sv
module pc_event_cam #(
    parameter int SIG_W = 33,
    parameter int EVT_N = 62,
    localparam int EIW  = (EVT_N > 1) ? $clog2(EVT_N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [EIW-1:0]   waddr,
    input  logic [SIG_W-1:0] wdata,
    input  logic             wvalid,
    input  logic [SIG_W-1:0] key,
    output logic             hit,
    output logic [EIW-1:0]   idx
);

    logic [EVT_N-1:0] match;

    for (genvar i = 0; i < EVT_N; i++) begin : g_entry
        localparam logic [EIW-1:0] MY_ADDR = EIW'(i);
        logic             ent_v;
        logic [SIG_W-1:0] ent_d;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_v <= 1'b0;
                ent_d <= '0;
            end else if (we && waddr == MY_ADDR) begin
                ent_v <= wvalid;
                ent_d <= wdata;
            end
        end

        assign match[i] = ent_v && (ent_d == key);
    end

    // lowest matching address wins
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = EVT_N - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                idx = EIW'(i);
            end
        end
    end

    logic [EVT_N-1:0] below_mask;
    always_comb begin
        for (int i = 0; i < EVT_N; i++) begin
            below_mask[i] = (EIW'(i) < idx);
        end
    end

    assert_hit_is_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> |(match & (EVT_N'(1) << idx)));

    assert_lowest_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((match & below_mask) == '0));

endmodule

// File: rtl/pc_trans_cam.sv
module pc_trans_cam #(
    parameter int EVT_N = 62,
    parameter int TRN_N = 622,
    localparam int EIW  = (EVT_N > 1) ? $clog2(EVT_N) : 1,
    localparam int TAW  = (TRN_N > 1) ? $clog2(TRN_N) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [TAW-1:0] waddr,
    input  logic [EIW-1:0] wsrc,
    input  logic [EIW-1:0] wdst,
    input  logic           wvalid,
    input  logic [EIW-1:0] prev_idx,
    input  logic [EIW-1:0] cur_idx,
    output logic           legal
);

    logic [TRN_N-1:0] match;

    for (genvar t = 0; t < TRN_N; t++) begin : g_edge
        localparam logic [TAW-1:0] MY_ADDR = TAW'(t);
        logic           ent_v;
        logic [EIW-1:0] ent_s;
        logic [EIW-1:0] ent_d;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_v <= 1'b0;
                ent_s <= '0;
                ent_d <= '0;
            end else if (we && waddr == MY_ADDR) begin
                ent_v <= wvalid;
                ent_s <= wsrc;
                ent_d <= wdst;
            end
        end

        assign match[t] = ent_v && (ent_s == prev_idx) && (ent_d == cur_idx);
    end

    assign legal = |match;

endmodule

// File: rtl/proto_checker.sv
module proto_checker #(
    parameter int SIG_W = 33,
    parameter int EVT_N = 62,
    parameter int TRN_N = 622,
    localparam int EIW  = (EVT_N > 1) ? $clog2(EVT_N) : 1,
    localparam int TAW  = (TRN_N > 1) ? $clog2(TRN_N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_we,
    input  logic [EIW-1:0]   evt_waddr,
    input  logic [SIG_W-1:0] evt_wdata,
    input  logic             evt_wvalid,
    input  logic             trn_we,
    input  logic [TAW-1:0]   trn_waddr,
    input  logic [EIW-1:0]   trn_wsrc,
    input  logic [EIW-1:0]   trn_wdst,
    input  logic             trn_wvalid,
    input  logic             chk_en,
    input  logic             err_clr,
    input  logic [SIG_W-1:0] sample_vec,
    output logic             evt_valid,
    output logic [EIW-1:0]   evt_idx,
    output logic             err_flag,
    output logic [1:0]       err_cause,
    output logic             halt_req
);

    import pc_pkg::*;

    pc_state_e      state, state_nx;
    pc_cause_e      cause_q;
    logic           ev_hit;
    logic [EIW-1:0] ev_idx;
    logic [EIW-1:0] prev_idx;
    logic           tr_legal;

    pc_event_cam #(.SIG_W(SIG_W), .EVT_N(EVT_N)) u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (evt_we),
        .waddr  (evt_waddr),
        .wdata  (evt_wdata),
        .wvalid (evt_wvalid),
        .key    (sample_vec),
        .hit    (ev_hit),
        .idx    (ev_idx)
    );

    pc_trans_cam #(.EVT_N(EVT_N), .TRN_N(TRN_N)) u_trn (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (trn_we),
        .waddr    (trn_waddr),
        .wsrc     (trn_wsrc),
        .wdst     (trn_wdst),
        .wvalid   (trn_wvalid),
        .prev_idx (prev_idx),
        .cur_idx  (ev_idx),
        .legal    (tr_legal)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (chk_en) state_nx = ST_PRIME;
            ST_PRIME:  if (!chk_en)     state_nx = ST_IDLE;
                       else if (!ev_hit) state_nx = ST_HALTED;
                       else              state_nx = ST_CHECK;
            ST_CHECK:  if (!chk_en)                 state_nx = ST_IDLE;
                       else if (!ev_hit || !tr_legal) state_nx = ST_HALTED;
                       else                          state_nx = ST_CHECK;
            ST_HALTED: if (err_clr) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_idx   <= '0;
            prev_idx  <= '0;
            cause_q   <= CAUSE_NONE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    evt_valid <= 1'b0;
                    cause_q   <= CAUSE_NONE;
                end
                ST_PRIME, ST_CHECK: begin
                    if (!chk_en) begin
                        evt_valid <= 1'b0;
                    end else begin
                        evt_valid <= ev_hit;
                        if (ev_hit) begin
                            evt_idx  <= ev_idx;
                            prev_idx <= ev_idx;
                        end
                        if (!ev_hit)
                            cause_q <= CAUSE_UNKNOWN;
                        else if (state == ST_CHECK && !tr_legal)
                            cause_q <= CAUSE_ILLEGAL;
                    end
                end
                ST_HALTED: begin
                    if (err_clr) begin
                        evt_valid <= 1'b0;
                        cause_q   <= CAUSE_NONE;
                    end
                end
                default: ;
            endcase
        end
    end

    assign err_flag  = (state == ST_HALTED);
    assign halt_req  = (state == ST_HALTED);
    assign err_cause = cause_q;

    assert_unknown_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_PRIME, ST_CHECK}) && chk_en && !ev_hit
        |=> err_flag && halt_req && err_cause == CAUSE_UNKNOWN && !evt_valid);

    assert_prime_skips_trans_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRIME) && chk_en && ev_hit |=> !err_flag);

    assert_illegal_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK) && chk_en && ev_hit && !tr_legal
        |=> err_flag && err_cause == CAUSE_ILLEGAL && evt_valid);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && !err_clr |=> err_flag && $stable(err_cause) && $stable(evt_idx)
                                 && $stable(evt_valid));

    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !err_flag && !chk_en |=> !evt_valid && !err_flag);

endmodule

// File: tb/tb_proto_checker.sv
module tb_proto_checker;

    localparam int SIG_W = 8;
    localparam int EVT_N = 8;
    localparam int TRN_N = 16;
    localparam int EIW   = 3;
    localparam int TAW   = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             evt_we = 1'b0;
    logic [EIW-1:0]   evt_waddr = '0;
    logic [SIG_W-1:0] evt_wdata = '0;
    logic             evt_wvalid = 1'b0;
    logic             trn_we = 1'b0;
    logic [TAW-1:0]   trn_waddr = '0;
    logic [EIW-1:0]   trn_wsrc = '0;
    logic [EIW-1:0]   trn_wdst = '0;
    logic             trn_wvalid = 1'b0;
    logic             chk_en = 1'b0;
    logic             err_clr = 1'b0;
    logic [SIG_W-1:0] sample_vec = '0;
    logic             evt_valid;
    logic [EIW-1:0]   evt_idx;
    logic             err_flag;
    logic [1:0]       err_cause;
    logic             halt_req;

    proto_checker #(.SIG_W(SIG_W), .EVT_N(EVT_N), .TRN_N(TRN_N)) dut (.*);

    always #5 clk = ~clk;

    typedef struct {
        int         due;
        logic       v;
        logic [2:0] idx;
        logic       err;
        logic [1:0] cause;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   edges = 0;
    int   n_tests = 0;
    int   n_fail = 0;
    bit   done = 0;

    // monitor: compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            edges++;
            #2;
            while (q.size() > 0 && q[0].due == edges) begin
                exp_t e;
                e = q.pop_front();
                n_tests++;
                if (evt_valid !== e.v || (e.v && evt_idx !== e.idx) || err_flag !== e.err
                    || halt_req !== e.err || err_cause !== e.cause) begin
                    n_fail++;
                    $display("FAIL %s: got v=%0b idx=%0d err=%0b halt=%0b cause=%0d, expected v=%0b idx=%0d err=%0b cause=%0d",
                             e.tag, evt_valid, evt_idx, err_flag, halt_req, err_cause,
                             e.v, e.idx, e.err, e.cause);
                end
            end
        end
    end

    task automatic step(input logic [7:0] vec, input logic en, input logic clr,
                        input logic ev, input int ei, input logic ee,
                        input logic [1:0] ec, input string tag);
        exp_t e;
        @(negedge clk);
        sample_vec = vec;
        chk_en     = en;
        err_clr    = clr;
        e.due = edges + 1; e.v = ev; e.idx = 3'(ei); e.err = ee; e.cause = ec; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic prog_evt(input int a, input logic [7:0] d, input logic v);
        @(negedge clk);
        evt_we = 1'b1; evt_waddr = 3'(a); evt_wdata = d; evt_wvalid = v;
        @(negedge clk);
        evt_we = 1'b0;
    endtask

    task automatic prog_trn(input int a, input int s, input int d, input logic v);
        @(negedge clk);
        trn_we = 1'b1; trn_waddr = 4'(a); trn_wsrc = 3'(s); trn_wdst = 3'(d); trn_wvalid = v;
        @(negedge clk);
        trn_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        n_tests++;
        if (evt_valid !== 1'b0 || err_flag !== 1'b0 || halt_req !== 1'b0 || err_cause !== 2'b00) begin
            n_fail++;
            $display("FAIL R1: got v=%0b err=%0b halt=%0b cause=%0d, expected all 0",
                     evt_valid, err_flag, halt_req, err_cause);
        end

        prog_evt(0, 8'h00, 1);
        prog_evt(1, 8'h0C, 1);
        prog_evt(2, 8'h04, 1);
        prog_evt(3, 8'h02, 1);
        prog_evt(4, 8'h05, 1);
        prog_evt(5, 8'h04, 1);   // duplicate of slot 2
        prog_evt(6, 8'h77, 1);
        prog_evt(6, 8'h77, 0);   // invalidated
        prog_evt(7, 8'h33, 0);   // never valid
        prog_trn(0, 0, 0, 1);
        prog_trn(1, 0, 2, 1);
        prog_trn(2, 2, 2, 1);
        prog_trn(3, 2, 0, 1);
        prog_trn(4, 0, 1, 1);
        prog_trn(5, 1, 0, 1);
        prog_trn(6, 2, 3, 1);
        prog_trn(7, 3, 0, 1);
        prog_trn(8, 3, 3, 1);
        prog_trn(8, 3, 3, 0);    // invalidated self loop
        prog_trn(9, 4, 0, 1);

        step(8'h00, 1, 0, 0, 0, 0, 2'b00, "R9 enable enters prime");
        step(8'h05, 1, 0, 1, 4, 0, 2'b00, "R7 first sample event only");
        step(8'h00, 1, 0, 1, 0, 0, 2'b00, "R2 legal 4->0");
        step(8'h04, 1, 0, 1, 2, 0, 2'b00, "R3 duplicate reports lower slot");
        step(8'h02, 1, 0, 1, 3, 0, 2'b00, "R2 legal 2->3");
        step(8'h02, 1, 0, 1, 3, 1, 2'b10, "R10 invalidated self loop illegal");
        step(8'h00, 1, 0, 1, 3, 1, 2'b10, "R8 held while halted");
        step(8'h77, 1, 0, 1, 3, 1, 2'b10, "R8 unknown ignored while halted");
        step(8'h00, 1, 1, 0, 0, 0, 2'b00, "R8 clear returns to idle");
        step(8'h00, 1, 0, 0, 0, 0, 2'b00, "R9 idle to prime");
        step(8'h0C, 1, 0, 1, 1, 0, 2'b00, "R7 stale pair 3->1 not checked");
        step(8'h00, 1, 0, 1, 0, 0, 2'b00, "R2 legal 1->0");
        step(8'h77, 1, 0, 0, 0, 1, 2'b01, "R4 invalidated event misses");
        step(8'h00, 0, 1, 0, 0, 0, 2'b00, "R8 clear");
        step(8'h33, 0, 0, 0, 0, 0, 2'b00, "R9 disabled ignores unknown");
        step(8'h33, 1, 0, 0, 0, 0, 2'b00, "R9 enable edge ignores sample");
        step(8'h33, 1, 0, 0, 0, 1, 2'b01, "R5 never valid slot is unknown");
        step(8'h00, 1, 1, 0, 0, 0, 2'b00, "R8 clear");
        step(8'h00, 1, 0, 0, 0, 0, 2'b00, "R9 to prime");
        step(8'h00, 1, 0, 1, 0, 0, 2'b00, "R2 prime on 0");
        step(8'h00, 1, 0, 1, 0, 0, 2'b00, "R2 self loop 0->0");
        step(8'h0C, 1, 0, 1, 1, 0, 2'b00, "R2 legal 0->1");
        step(8'h04, 1, 0, 1, 2, 1, 2'b10, "R6 unprogrammed 1->2");
        step(8'h00, 1, 1, 0, 0, 0, 2'b00, "R8 clear");
        step(8'h00, 1, 0, 0, 0, 0, 2'b00, "R9 to prime");
        step(8'h00, 1, 0, 1, 0, 0, 2'b00, "R2 prime on 0");
        step(8'h33, 0, 0, 0, 0, 0, 2'b00, "R9 drop enable mid-check");
        step(8'h02, 1, 0, 0, 0, 0, 2'b00, "R9 re-enable");
        step(8'h02, 1, 0, 1, 3, 0, 2'b00, "R7 pair 0->3 skipped after re-enable");
        step(8'h00, 1, 0, 1, 0, 0, 2'b00, "R2 legal 3->0");

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            n_tests++;
            n_fail++;
            $display("FAIL scoreboard: got %0d pending, expected 0", q.size());
        end
        finish_run();
    end

endmodule